// File: doc/BRIEF.md
# Per-CPU Dual Inter-Processor Interrupt Unit

This block holds two inter-processor interrupts (IPIs) for each CPU of a small cluster. The first kind is "other", which a CPU raises on any group of CPUs. The second kind is "self", which a CPU raises only on itself. Software reaches the block over a simple 32-bit write bus. A CPU-id input selects whose view a write acts on, and that view is the one shown on the event port. Each CPU has three bit-mapped write registers: acknowledge, mask-set and mask-clear. Each CPU also has its own interrupt line, which is high while any of its IPIs is pending and unmasked.

The event port is a valid/ready stream into the neighbouring event-register logic. When an IPI of the selected CPU is pending and unmasked, `evt_valid` is high and `evt_data` carries the event code. A transfer happens in any cycle where `evt_valid` and `evt_ready` are both high. That transfer is the delivery, and it sets the delivered IPI's mask bit on the next edge. The pending bit stays set until software acknowledges it. Software then clears the mask to receive more IPIs. A low `evt_ready` holds nothing back: the offer simply stays as long as the state allows, and it may change whenever the CPU id or the state changes. A pending hardware interrupt of the selected CPU takes precedence, so no IPI event is offered while one is present.

Top module: `ipi_unit`

## Requirements
- R1: A write to the send register (word address 0) raises the "other" IPI on CPU c for every data bit c that is set, for c below NUM_CPU. Higher data bits are ignored.
- R2: A write to the self-trigger register (word address 1) with data bit 31 set raises the "self" IPI only on the CPU given by `cpu_id`.
- R3: A write to the acknowledge register (word address 2) clears the pending "other" IPI of `cpu_id` when data bit 0 is set, and clears the pending "self" IPI when data bit 31 is set.
- R4: Writes to mask-set (word address 3) and mask-clear (word address 4) set or clear the mask of `cpu_id`, with bit 0 for "other" and bit 31 for "self". A pending IPI drives `irq_out` once it is unmasked.
- R5: While `evt_valid` is high, `evt_data[23:16]` is 4 and `evt_data[15:0]` is 1 for "other" or 2 for "self". All other bits are zero. When both IPIs are pending and unmasked, "other" is offered.
- R6: A transfer on the event port sets the mask bit of the delivered IPI on the next edge. The pending bit is kept, so clearing the mask brings the IPI back.
- R7: While `hw_pend[cpu_id]` is high, `evt_valid` is low, and `evt_ready` changes no state.
- R8: Reset clears every pending IPI and sets every mask bit. After reset `irq_out` is 0 and `evt_valid` is low.
- R9: When a transfer and a mask-clear of the same IPI fall on the same edge, the IPI ends up masked.
- R10: `irq_out[c]` is high exactly when CPU c has an IPI that is pending and unmasked, whatever the state of `hw_pend`.
- R11: When `cpu_id` is not below NUM_CPU, the per-CPU writes change nothing and `evt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_id | input | CPU_W | CPU whose view is used by writes and the event port |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| hw_pend | input | NUM_CPU | Per-CPU hardware-interrupt pending flags |
| evt_valid | output | 1 | An IPI event is offered for `cpu_id` |
| evt_ready | input | 1 | Event logic takes the offered event |
| evt_data | output | 32 | Event code: type in [23:16], number in [15:0] |
| irq_out | output | NUM_CPU | Per-CPU IPI interrupt lines |

## Verification
The bench builds the block with NUM_CPU set to 3. The 2-bit CPU id can then also select id 3, which lies outside the cluster, so the ignored-write and no-event behaviour for an absent CPU can be reached. With three CPUs, send words whose high bits are set fall beyond the cluster, which checks that those bits are ignored. Each CPU can also be made to hold its own mix of pending and masked IPIs. Random cycles mix writes, view changes, hardware-pending flags and event transfers, so transfers that coincide with mask-clear writes arise on their own as well as in the directed cases.

// File: rtl/ipi_unit_pkg.sv
package ipi_unit_pkg;
  localparam int KIND_N     = 2;
  localparam int KIND_OTHER = 0;
  localparam int KIND_SELF  = 1;

  localparam int DATA_W       = 32;
  localparam int SEL_OTHER_BIT = 0;
  localparam int SEL_SELF_BIT  = 31;

  localparam int REG_SEND = 0;
  localparam int REG_SELF = 1;
  localparam int REG_ACK  = 2;
  localparam int REG_MSET = 3;
  localparam int REG_MCLR = 4;

  localparam logic [7:0]  EVT_TYPE_IPI  = 8'd4;
  localparam logic [15:0] EVT_NUM_OTHER = 16'd1;
  localparam logic [15:0] EVT_NUM_SELF  = 16'd2;

  typedef logic [KIND_N-1:0] kind_vec_t;
endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_unit_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2,
  parameter int ADDR_W  = 4
) (
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [CPU_W-1:0]          cpu_id,
  output kind_vec_t [NUM_CPU-1:0]   raise,
  output kind_vec_t [NUM_CPU-1:0]   ack,
  output kind_vec_t [NUM_CPU-1:0]   mset,
  output kind_vec_t [NUM_CPU-1:0]   mclr
);
  kind_vec_t sel;

  always_comb begin
    sel[KIND_OTHER] = wr_data[SEL_OTHER_BIT];
    sel[KIND_SELF]  = wr_data[SEL_SELF_BIT];
  end

  always_comb begin
    raise = '0;
    ack   = '0;
    mset  = '0;
    mclr  = '0;
    if (wr_en) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (wr_addr == ADDR_W'(REG_SEND))
          raise[c][KIND_OTHER] = wr_data[c];
        if (cpu_id == CPU_W'(c)) begin
          if (wr_addr == ADDR_W'(REG_SELF))
            raise[c][KIND_SELF] = wr_data[SEL_SELF_BIT];
          if (wr_addr == ADDR_W'(REG_ACK))  ack[c]  = sel;
          if (wr_addr == ADDR_W'(REG_MSET)) mset[c] = sel;
          if (wr_addr == ADDR_W'(REG_MCLR)) mclr[c] = sel;
        end
      end
    end
  end
endmodule

// File: rtl/ipi_cpu_state.sv
module ipi_cpu_state
  import ipi_unit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  kind_vec_t raise,
  input  kind_vec_t ack,
  input  kind_vec_t mset,
  input  kind_vec_t mclr,
  input  kind_vec_t take,
  output kind_vec_t pend,
  output kind_vec_t mask
);
  for (genvar k = 0; k < KIND_N; k++) begin : g_kind
    // new raise outranks acknowledge; delivery outranks mask clear
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[k] <= 1'b0;
        mask[k] <= 1'b1;
      end else begin
        pend[k] <= (pend[k] & ~ack[k]) | raise[k];
        mask[k] <= ((mask[k] | mset[k]) & ~mclr[k]) | take[k];
      end
    end
  end
endmodule

// File: rtl/ipi_evt_sel.sv
module ipi_evt_sel
  import ipi_unit_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic [CPU_W-1:0]        cpu_id,
  input  logic [NUM_CPU-1:0]      hw_pend,
  input  kind_vec_t [NUM_CPU-1:0] pend,
  input  kind_vec_t [NUM_CPU-1:0] mask,
  input  logic                    evt_ready,
  output logic                    evt_valid,
  output logic [DATA_W-1:0]       evt_data,
  output kind_vec_t [NUM_CPU-1:0] take,
  output logic [NUM_CPU-1:0]      irq_out
);
  kind_vec_t vis;
  logic      hw_sel;
  logic      id_ok;
  logic      pick_other;

  always_comb begin
    vis    = '0;
    hw_sel = 1'b0;
    id_ok  = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) begin
      irq_out[c] = |(pend[c] & ~mask[c]);
      if (cpu_id == CPU_W'(c)) begin
        vis    = pend[c] & ~mask[c];
        hw_sel = hw_pend[c];
        id_ok  = 1'b1;
      end
    end
  end

  assign pick_other = vis[KIND_OTHER];
  assign evt_valid  = id_ok && !hw_sel && (|vis);

  always_comb begin
    evt_data = '0;
    if (evt_valid) begin
      evt_data[23:16] = EVT_TYPE_IPI;
      evt_data[15:0]  = pick_other ? EVT_NUM_OTHER : EVT_NUM_SELF;
    end
  end

  always_comb begin
    take = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_id == CPU_W'(c) && evt_valid && evt_ready) begin
        take[c][KIND_OTHER] = pick_other;
        take[c][KIND_SELF]  = !pick_other;
      end
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_unit_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_W-1:0]   cpu_id,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [NUM_CPU-1:0] hw_pend,
  output logic               evt_valid,
  input  logic               evt_ready,
  output logic [31:0]        evt_data,
  output logic [NUM_CPU-1:0] irq_out
);
  kind_vec_t [NUM_CPU-1:0] raise, ack, mset, mclr, take, pend, mask;

  ipi_wr_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cpu_id(cpu_id),
    .raise(raise), .ack(ack), .mset(mset), .mclr(mclr)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    ipi_cpu_state u_state (
      .clk(clk), .rst_n(rst_n),
      .raise(raise[c]), .ack(ack[c]), .mset(mset[c]), .mclr(mclr[c]),
      .take(take[c]), .pend(pend[c]), .mask(mask[c])
    );
  end

  ipi_evt_sel #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_sel (
    .cpu_id(cpu_id), .hw_pend(hw_pend), .pend(pend), .mask(mask),
    .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_data(evt_data),
    .take(take), .irq_out(irq_out)
  );
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4,
  parameter int CPU_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CPU_W-1:0]   cpu_id,
  input logic               wr_en,
  input logic [NUM_CPU-1:0] hw_pend,
  input logic               evt_valid,
  input logic               evt_ready,
  input logic [31:0]        evt_data,
  input logic [NUM_CPU-1:0] irq_out
);
  logic hw_sel;
  always_comb begin
    hw_sel = 1'b0;
    for (int c = 0; c < NUM_CPU; c++)
      if (cpu_id == CPU_W'(c)) hw_sel = hw_pend[c];
  end

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_out == '0) && !evt_valid);

  // R7
  hw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_sel |-> !evt_valid);

  // R5
  evt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_data[31:16] == 16'h0004) &&
                  (evt_data[15:0] == 16'd1 || evt_data[15:0] == 16'd2));

  // R6
  auto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=>
      !(evt_valid && cpu_id == $past(cpu_id) && evt_data == $past(evt_data)));

  // R10
  no_write_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((irq_out & ~$past(irq_out)) == '0));
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .wr_en(wr_en), .hw_pend(hw_pend),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data), .irq_out(irq_out)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
  localparam int NC = 3;
  localparam int CW = 2;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cpu_id;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [NC-1:0] hw_pend;
  logic          evt_valid;
  logic          evt_ready;
  logic [31:0]   evt_data;
  logic [NC-1:0] irq_out;

  int total = 0;
  int bad   = 0;

  bit m_pend [NC][2];
  bit m_mask [NC][2];

  always #2.5 clk = ~clk;

  ipi_unit #(.NUM_CPU(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hw_pend(hw_pend), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_data(evt_data), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++)
      r[c] = (m_pend[c][0] && !m_mask[c][0]) || (m_pend[c][1] && !m_mask[c][1]);
    return r;
  endfunction

  function automatic logic [31:0] exp_evt(int cid, logic [NC-1:0] hw);
    bit v0, v1;
    if (cid >= NC || hw[cid]) return 32'h0;
    v0 = m_pend[cid][0] && !m_mask[cid][0];
    v1 = m_pend[cid][1] && !m_mask[cid][1];
    if (v0) return 32'h0004_0001;
    if (v1) return 32'h0004_0002;
    return 32'h0;
  endfunction

  // one clock with the given inputs; model follows; optional comparison
  task automatic step(bit we, int addr, logic [31:0] data, int cid,
                      logic [NC-1:0] hw, bit rdy, bit cmp);
    logic [31:0] ev;
    bit take0, take1;
    wr_en = we; wr_addr = AW'(addr); wr_data = data;
    cpu_id = CW'(cid); hw_pend = hw; evt_ready = rdy;
    #1;
    ev = exp_evt(cid, hw);
    if (cmp) begin
      check("R5 evt_valid", {31'b0, evt_valid}, {31'b0, ev != 0});
      check("R5 evt_data", evt_data, ev);
    end
    take0 = rdy && ev == 32'h0004_0001;
    take1 = rdy && ev == 32'h0004_0002;
    for (int c = 0; c < NC; c++) begin
      bit r0, r1, a0, a1, s0, s1, k0, k1;
      r0 = 0; r1 = 0; a0 = 0; a1 = 0; s0 = 0; s1 = 0; k0 = 0; k1 = 0;
      if (we && addr == 0) r0 = data[c];
      if (we && c == cid) begin
        if (addr == 1) r1 = data[31];
        if (addr == 2) begin a0 = data[0]; a1 = data[31]; end
        if (addr == 3) begin m_mask[c][0] |= data[0]; m_mask[c][1] |= data[31]; end
        if (addr == 4) begin s0 = data[0]; s1 = data[31]; end
      end
      if (c == cid) begin k0 = take0; k1 = take1; end
      m_pend[c][0] = (m_pend[c][0] && !a0) || r0;
      m_pend[c][1] = (m_pend[c][1] && !a1) || r1;
      m_mask[c][0] = (m_mask[c][0] && !s0) || k0;
      m_mask[c][1] = (m_mask[c][1] && !s1) || k1;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt_ready = 1'b0;
    if (cmp) check("R10 irq_out", 32'(irq_out), 32'(exp_irq()));
  endtask

  task automatic view(int cid, logic [NC-1:0] hw);
    cpu_id = CW'(cid); hw_pend = hw; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
    cpu_id = 0; hw_pend = 0; evt_ready = 0;
    for (int c = 0; c < NC; c++) begin
      m_pend[c][0] = 0; m_pend[c][1] = 0; m_mask[c][0] = 1; m_mask[c][1] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    view(0, 0);
    check("R8 irq_out after reset", 32'(irq_out), 32'h0);
    check("R8 evt_valid after reset", {31'b0, evt_valid}, 32'h0);

    // R8: unmasking with nothing pending gives nothing
    step(1, 4, 32'h8000_0001, 0, 0, 0, 0);
    check("R8 unmask idle", 32'(irq_out), 32'h0);

    // R1: bits 0 and 2 plus bits beyond the cluster
    step(1, 0, 32'hFFFF_FFF5, 1, 0, 0, 0);
    check("R1 send cpu0 only unmasked", 32'(irq_out), 32'h1);
    step(1, 4, 32'h0000_0001, 2, 0, 0, 0);
    check("R4 unmask cpu2 other", 32'(irq_out), 32'h5);
    step(1, 4, 32'h0000_0001, 1, 0, 0, 0);
    check("R1 cpu1 not raised", 32'(irq_out), 32'h5);

    view(0, 0);
    check("R5 other code", evt_data, 32'h0004_0001);
    view(0, 3'b001);
    check("R7 hw blocks valid", {31'b0, evt_valid}, 32'h0);
    step(0, 0, 0, 0, 3'b001, 1, 0);
    check("R7 ready ignored", 32'(irq_out), 32'h5);

    // R6 delivery masks, pending kept
    step(0, 0, 0, 0, 0, 1, 0);
    check("R6 masked after take", 32'(irq_out), 32'h4);
    view(0, 0);
    check("R6 no offer after take", {31'b0, evt_valid}, 32'h0);
    step(1, 4, 32'h0000_0001, 0, 0, 0, 0);
    check("R6 pending kept", 32'(irq_out), 32'h5);
    step(1, 2, 32'h0000_0001, 0, 0, 0, 0);
    check("R3 ack clears", 32'(irq_out), 32'h4);

    // R2 self trigger on cpu1
    step(1, 4, 32'h8000_0000, 1, 0, 0, 0);
    step(1, 1, 32'h8000_0000, 1, 0, 0, 0);
    check("R2 self on writer only", 32'(irq_out), 32'h6);
    view(1, 0);
    check("R5 self code", evt_data, 32'h0004_0002);
    step(1, 0, 32'h0000_0002, 1, 0, 0, 0);
    view(1, 0);
    check("R5 other preferred", evt_data, 32'h0004_0001);
    step(1, 3, 32'h0000_0001, 1, 0, 0, 0);
    view(1, 0);
    check("R4 mask set other", evt_data, 32'h0004_0002);
    step(1, 4, 32'h0000_0001, 1, 0, 0, 0);

    // R9 take and mask clear together
    step(1, 4, 32'h0000_0001, 1, 0, 1, 0);
    view(1, 0);
    check("R9 take beats clear", evt_data, 32'h0004_0002);

    // R11 absent CPU id
    step(1, 2, 32'h8000_0001, 3, 0, 0, 0);
    step(1, 1, 32'h8000_0000, 3, 0, 0, 0);
    check("R11 ignored writes", 32'(irq_out), 32'h6);
    view(3, 0);
    check("R11 no event", {31'b0, evt_valid}, 32'h0);

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      bit we;
      int addr, cid;
      logic [31:0] d;
      we   = ($urandom % 3) != 0;
      addr = $urandom % 6;
      cid  = $urandom % 4;
      d    = $urandom;
      step(we, addr, d, cid, NC'($urandom % 8 == 0 ? $urandom : 0),
           ($urandom % 2) == 1, 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule